// File: doc/BRIEF.md
# Clock Correction Sequence Detector

This block watches a stream of decoded receive symbols and reports where a programmed clock correction sequence ends. Each symbol is an 8-bit value with two flags: one marks a control (K) character, and the other marks inverted running disparity. The block keeps a sliding window of the most recently accepted symbols and compares it with two programmable sequences. Each sequence holds up to four slots, and each slot can be masked so that it matches any symbol.

A downstream elastic buffer uses the match strobe to decide where it may insert or remove a sequence. The strobe says which sequence matched and how long the match was. Buffering, insertion, removal, 8B/10B decoding and comma alignment are left to other blocks.

Top module: `ccseq_match`

## Requirements
- R1: A slot is a 10-bit pattern: bits 7:0 hold the data byte, bit 8 holds the K flag and bit 9 holds the inverted-disparity flag. An enabled slot matches only when all ten bits equal the incoming symbol's `{in_inv, in_k, in_data}`.
- R2: When a slot's enable bit in `seqN_care` is 0, that slot matches any symbol.
- R3: `cfg_len` selects the sequence length: 0 gives 1 symbol, 1 gives 2 symbols, and 2 or 3 give 4 symbols. Slot i of a pattern sits at bits `[10*(i-1) +: 10]` and its enable at bit i-1. Slot 1 is compared with the earliest of the last L accepted symbols and slot L with the newest. Slots above L are ignored.
- R4: When the symbol accepted at a rising edge completes a match, `hit` is 1 for the cycle that follows that edge. In that cycle `hit_len` shows the length in use (1, 2 or 4).
- R5: While `cfg_seq2_en` is 0, sequence 2 never produces a hit.
- R6: When both sequences match on the same symbol, sequence 1 is reported and `hit_seq2` is 0. A hit from sequence 2 alone sets `hit_seq2` to 1.
- R7: Reset empties the window and drives all outputs to 0. No hit is reported until at least L valid symbols have been accepted since reset.
- R8: A cycle with `in_valid` low does not shift the window and produces no hit on the following cycle.
- R9: While `hit` is 0, `hit_seq2` and `hit_len` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Symbol qualifier |
| in_data | input | 8 | Decoded data byte |
| in_k | input | 1 | Symbol is a K character |
| in_inv | input | 1 | Symbol has inverted disparity |
| cfg_len | input | 2 | Length select (1, 2, 4, 4) |
| cfg_seq2_en | input | 1 | Enables sequence 2 |
| seq1_pat | input | 40 | Sequence 1 slot patterns |
| seq1_care | input | 4 | Sequence 1 slot enables |
| seq2_pat | input | 40 | Sequence 2 slot patterns |
| seq2_care | input | 4 | Sequence 2 slot enables |
| hit | output | 1 | Match strobe |
| hit_seq2 | output | 1 | 1 when the hit came from sequence 2 |
| hit_len | output | 3 | Length of the match |

## Verification
The cases hardest to reach from the ports are two: both sequences matching on the same symbol under different don't-care masks, and a match landing exactly on the fill boundary after reset or after a run of invalid cycles. Exact four-slot matches are rare in arbitrary traffic. The bench therefore draws symbols from an eight-symbol alphabet (two data bytes crossed with both flags), which makes matches frequent. It then sweeps every length code, both states of the sequence 2 enable and all sixteen masks of sequence 1. It inserts invalid cycles and periodic resets, so that early-fill and simultaneous-match cases occur many times.

// File: rtl/ccseq_match.sv
module ccseq_match #(
  parameter int DW    = 8,
  parameter int SLOTS = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  in_valid,
  input  logic [DW-1:0]         in_data,
  input  logic                  in_k,
  input  logic                  in_inv,
  input  logic [1:0]            cfg_len,
  input  logic                  cfg_seq2_en,
  input  logic [SLOTS*(DW+2)-1:0] seq1_pat,
  input  logic [SLOTS-1:0]      seq1_care,
  input  logic [SLOTS*(DW+2)-1:0] seq2_pat,
  input  logic [SLOTS-1:0]      seq2_care,
  output logic                  hit,
  output logic                  hit_seq2,
  output logic [2:0]            hit_len
);
  localparam int SW = DW + 2;
  localparam int NH = SLOTS - 1;
  localparam int FW = $clog2(SLOTS + 1);

  logic [SW-1:0] hist [NH];
  logic [SW-1:0] win  [SLOTS];
  logic [FW-1:0] fill;
  logic [2:0]    len;
  logic          m1, m2, full;

  assign len = (cfg_len == 2'd0) ? 3'd1 : (cfg_len == 2'd1) ? 3'd2 : 3'd4;

  always_comb begin
    win[0] = {in_inv, in_k, in_data};
    for (int a = 1; a < SLOTS; a++) win[a] = hist[a-1];
  end

  always_comb begin
    m1 = 1'b1;
    m2 = 1'b1;
    for (int j = 0; j < SLOTS; j++)
      for (int a = 0; a < SLOTS; a++)
        if (j + a + 1 == int'(len)) begin
          if (seq1_care[j] && seq1_pat[j*SW +: SW] != win[a]) m1 = 1'b0;
          if (seq2_care[j] && seq2_pat[j*SW +: SW] != win[a]) m2 = 1'b0;
        end
  end

  assign full = (int'(fill) + 1) >= int'(len);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fill <= '0;
      for (int a = 0; a < NH; a++) hist[a] <= '0;
    end else if (in_valid) begin
      if (int'(fill) < SLOTS) fill <= fill + 1'b1;
      hist[0] <= win[0];
      for (int a = 1; a < NH; a++) hist[a] <= hist[a-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit      <= 1'b0;
      hit_seq2 <= 1'b0;
      hit_len  <= '0;
    end else begin
      hit      <= in_valid && full && (m1 || (cfg_seq2_en && m2));
      hit_seq2 <= in_valid && full && !m1 && cfg_seq2_en && m2;
      hit_len  <= (in_valid && full && (m1 || (cfg_seq2_en && m2))) ? len : 3'd0;
    end
  end
endmodule

module ccseq_match_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       in_valid,
  input logic [1:0] cfg_len,
  input logic       cfg_seq2_en,
  input logic       hit,
  input logic       hit_seq2,
  input logic [2:0] hit_len
);
  logic [2:0] seen;
  always_ff @(posedge clk) begin
    if (!rst_n) seen <= '0;
    else if (in_valid && seen != 3'd7) seen <= seen + 1'b1;
  end

  p_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !hit);
  p_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !hit |-> (!hit_seq2 && hit_len == 3'd0));
  p_seq2_off_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && hit_seq2) |-> $past(cfg_seq2_en));
  p_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> hit_len == (($past(cfg_len) == 2'd0) ? 3'd1 :
                        ($past(cfg_len) == 2'd1) ? 3'd2 : 3'd4));
  p_fill_r7: assert property (@(posedge clk) disable iff (!rst_n)
    hit |-> seen >= hit_len);
endmodule

bind ccseq_match ccseq_match_chk u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .cfg_len(cfg_len),
  .cfg_seq2_en(cfg_seq2_en), .hit(hit), .hit_seq2(hit_seq2), .hit_len(hit_len)
);

// File: tb/ccseq_match_test.sv
module ccseq_match_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = '0;
  logic        in_k = 1'b0, in_inv = 1'b0;
  logic [1:0]  cfg_len = '0;
  logic        cfg_seq2_en = 1'b0;
  logic [39:0] seq1_pat = '0, seq2_pat = '0;
  logic [3:0]  seq1_care = '0, seq2_care = '0;
  logic        hit, hit_seq2;
  logic [2:0]  hit_len;

  int checks = 0, errors = 0;
  logic [9:0] mh [4];
  int mcnt = 0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  ccseq_match uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic bit mseq(logic [39:0] pat, logic [3:0] care, int L);
    for (int j = 0; j < L; j++)
      if (care[j] && pat[10*j +: 10] != mh[L-1-j]) return 1'b0;
    return 1'b1;
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; in_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    mcnt = 0;
    for (int i = 0; i < 4; i++) mh[i] = '0;
  endtask

  // drive at negedge, sample at the following negedge
  task automatic step(bit v, logic [9:0] sym, string req);
    int L; bit m1, m2, e_hit, e_s2;
    in_valid = v; {in_inv, in_k, in_data} = sym;
    L = (cfg_len == 0) ? 1 : (cfg_len == 1) ? 2 : 4;
    if (v) begin
      for (int i = 3; i > 0; i--) mh[i] = mh[i-1];
      mh[0] = sym;
      if (mcnt < 4) mcnt++;
    end
    m1 = mseq(seq1_pat, seq1_care, L);
    m2 = cfg_seq2_en && mseq(seq2_pat, seq2_care, L);
    e_hit = v && mcnt >= L && (m1 || m2);
    e_s2 = e_hit && !m1;
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    chk({req, " hit"}, int'(hit), int'(e_hit));
    chk({req, " seq2"}, int'(hit_seq2), int'(e_s2));
    chk({req, " len"}, int'(hit_len), e_hit ? L : 0);
  endtask

  function automatic logic [9:0] asym(logic [2:0] c);
    return {c[2], c[1], c[0] ? 8'h1C : 8'hBC};
  endfunction

  localparam logic [9:0] A = 10'h1BC;  // K, regular disparity
  localparam logic [9:0] B = 10'h11C;

  initial begin
    do_reset();
    chk("R7 reset hit", int'(hit), 0);
    chk("R9 reset len", int'(hit_len), 0);

    // R1: exact compare on all ten bits
    cfg_len = 0; seq1_pat = {30'd0, A}; seq1_care = 4'b0001;
    step(1, A, "R1 exact");           chk("R1 exact lit", int'(hit), 1);
    step(1, A & 10'h2FF, "R1 k");     chk("R1 k lit", int'(hit), 0);
    step(1, A | 10'h200, "R1 disp");  chk("R1 disp lit", int'(hit), 0);
    step(1, B, "R1 data");            chk("R1 data lit", int'(hit), 0);
    // R2: masked slot matches anything
    seq1_care = 4'b0000;
    step(1, B, "R2 dontcare");        chk("R2 lit", int'(hit), 1);
    // R3: order, slot 1 earliest
    do_reset();
    cfg_len = 1; seq1_pat = {20'd0, B, A}; seq1_care = 4'b0011;
    step(1, B, "R3 b"); step(1, A, "R3 ba"); chk("R3 rev lit", int'(hit), 0);
    step(1, B, "R3 ab");              chk("R4 ab lit", int'(hit), 1);
    chk("R4 len lit", int'(hit_len), 2);
    // R8: invalid cycle does not shift
    step(1, A, "R8 a"); step(0, B, "R8 gap"); chk("R8 gap lit", int'(hit), 0);
    step(1, B, "R8 b");               chk("R8 kept lit", int'(hit), 1);
    // R7: fill boundary, length 4 all don't care
    do_reset();
    cfg_len = 3; seq1_care = 4'b0000;
    for (int i = 0; i < 3; i++) begin step(1, A, "R7 fill"); chk("R7 fill lit", int'(hit), 0); end
    step(1, A, "R7 full");            chk("R7 full lit", int'(hit), 1);
    chk("R3 code3 len", int'(hit_len), 4);
    // R5/R6
    cfg_len = 0; seq1_pat = {30'd0, A}; seq1_care = 4'b0001;
    seq2_pat = {30'd0, B}; seq2_care = 4'b0001; cfg_seq2_en = 0;
    step(1, B, "R5 off");             chk("R5 off lit", int'(hit), 0);
    cfg_seq2_en = 1;
    step(1, B, "R6 s2");              chk("R6 s2 lit", int'(hit_seq2), 1);
    seq2_pat = {30'd0, A};
    step(1, A, "R6 both");            chk("R6 prio lit", int'(hit_seq2), 0);
    chk("R6 both hit", int'(hit), 1);

    // sweep
    seq1_pat = {asym(3'd0), asym(3'd3), asym(3'd5), asym(3'd6)};
    seq2_pat = {asym(3'd1), asym(3'd3), asym(3'd4), asym(3'd6)};
    seq2_care = 4'b1010;
    for (int ln = 0; ln < 4; ln++)
      for (int en = 0; en < 2; en++)
        for (int m = 0; m < 16; m++) begin
          do_reset();
          cfg_len = 2'(ln); cfg_seq2_en = 1'(en); seq1_care = 4'(m);
          for (int s = 0; s < 40; s++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[4:3] != 2'b00, asym(lfsr[2:0]), "R4 sweep");
          end
        end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #800000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule